// File: doc/BRIEF.md
# System control register file

This block is a bank of 32-bit control and status words inside a 4 KiB byte window. A simple synchronous bus reaches it. A requester presents a byte offset, a write flag, an access size and up to 64 bits of write data for one cycle. One cycle later the block returns an acknowledge, an error flag and the read data. Words sit at byte offset index × 4, and the bus is little-endian: in a 64-bit access the lower-indexed word travels in bits 31:0.

Each word has a fixed access policy. The policy is one of plain read/write, read-only, write-1-to-clear or write-1-to-set. Reset loads each word with a cold constant, with three exceptions. Two words load external strap and module-disable inputs. Two more words carry a DRAM size that is fixed at elaboration as a power-of-two exponent. The upper part of the bank is a scratch and semaphore area. Only that area also takes paired 64-bit accesses.

Default map (word index: meaning, policy, reset):

| Index | Word | Policy | Reset value |
|---|---|---|---|
| 0 | device identity | read-only | `DEV_ID` |
| 1 | strap capture | read-only | `strapIn` |
| 2 | interrupt status | read-only | 0 |
| 3 | control A | read/write | 0x0000035E |
| 4 | memory config | read/write | 0x00080000 (bit 19 means DRAM ready) |
| 5 | reset cause | write-1-to-clear | 0x80000000 |
| 6 | boot status | write-1-to-clear | 0x000000C0 |
| 7 | lock | write-1-to-set | 0 |
| 8 | module disable | write-1-to-set | `modDisIn` |
| 9 | DRAM control | read/write | 0x00001002 OR ((DRAM_LOG2 − 27) << 8) |
| 10 | DRAM bytes | read/write | 2^DRAM_LOG2 |
| 11 to 55 | scratch | read/write | 0 |
| 56 to 63 | semaphores | read/write | 1 |

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the cold constants read back as follows. Index 0 reads DEV_ID, index 3 reads 0x0000035E, index 4 reads 0x00080000, index 5 reads 0x80000000 and index 6 reads 0x000000C0. Every semaphore word (index SEM_BASE up to NUM_REGS−1) reads 1.
- R2: After reset, index 1 holds the value of `strapIn` and index 8 holds the value of `modDisIn`, both as sampled during reset.
- R3: After reset, index 9 holds 0x00001002 OR ((DRAM_LOG2 − 27) << 8), and index 10 holds 2^DRAM_LOG2. DRAM_LOG2 must lie in the range 27 to 31; any other value is rejected at elaboration.
- R4: A 32-bit access uses `sizeIn`=2 at byte offset index×4. It writes a read/write word with `wdataIn[31:0]`. On a read it returns the word in `rdataOut[31:0]` with the upper half zero.
- R5: Writes to indices 0, 1 and 2 are acknowledged without error and change nothing.
- R6: A write to index 5 or 6 leaves old AND NOT data, so ones in the write data clear bits.
- R7: A write to index 7 or 8 leaves old OR data, so bits only set until the next reset.
- R8: A 64-bit access uses `sizeIn`=3 at an even index N with WIDE_BASE ≤ N ≤ NUM_REGS−2. It moves word N in bits 31:0 and word N+1 in bits 63:32.
- R9: A 64-bit access at an odd index, or at an index outside the R8 range, reports an error. Its read data is zero and no word changes.
- R10: An access whose `sizeIn` is 0 or 1, or whose offset bits 1:0 are non-zero, reports an error. Its read data is zero and no word changes.
- R11: An access whose index is NUM_REGS or higher, but still inside the 4 KiB window, reports an error. It reads zero and writes nothing.
- R12: `ackOut` is high exactly in the cycle after each cycle where `reqIn` is high. `errOut` is only ever high together with `ackOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | synchronous active-low reset |
| strapIn | input | 32 | strap value loaded into index 1 during reset |
| modDisIn | input | 32 | module-disable value loaded into index 8 during reset |
| reqIn | input | 1 | access request, one cycle per access |
| wrIn | input | 1 | 1 for write, 0 for read |
| addrIn | input | 12 | byte offset in the 4 KiB window |
| sizeIn | input | 2 | 0 byte, 1 half, 2 word, 3 double word |
| wdataIn | input | 64 | write data, word N in bits 31:0 |
| ackOut | output | 1 | response strobe, one cycle after the request |
| errOut | output | 1 | access rejected, valid with ackOut |
| rdataOut | output | 64 | read data, valid with ackOut, zero otherwise |

## Verification
Suppose a word takes the wrong policy or a wrong reset source. The error stays hidden until that word is read back, and then it appears on `rdataOut` one cycle after the read request. For this reason every word class is read after reset and again after each kind of write. A decode fault shows at once: the next cycle's `errOut` is wrong, or a neighbouring word is corrupted and shows up on a later read. The reference model tracks the whole map, so any such divergence is flagged in the first cycle where the ports differ.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned WIN_BYTES  = 4096;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned REG_IDX_W  = $clog2(WIN_BYTES / WORD_BYTES);

  // fixed word indices of the control part of the map
  localparam int unsigned IDX_DEVID    = 0;
  localparam int unsigned IDX_STRAP    = 1;
  localparam int unsigned IDX_IRQSTAT  = 2;
  localparam int unsigned IDX_CTRLA    = 3;
  localparam int unsigned IDX_MEMCFG   = 4;
  localparam int unsigned IDX_RSTCAUSE = 5;
  localparam int unsigned IDX_BOOTSTAT = 6;
  localparam int unsigned IDX_LOCK     = 7;
  localparam int unsigned IDX_MODDIS   = 8;
  localparam int unsigned IDX_DRAMCTL  = 9;
  localparam int unsigned IDX_DRAMSIZE = 10;
  localparam int unsigned NUM_FIXED    = 11;

  localparam logic [31:0] CTRLA_COLD    = 32'h0000_035E;
  localparam logic [31:0] MEMCFG_COLD   = 32'h0008_0000;
  localparam logic [31:0] RSTCAUSE_COLD = 32'h8000_0000;
  localparam logic [31:0] BOOTSTAT_COLD = 32'h0000_00C0;
  localparam logic [31:0] DRAMCTL_BASE  = 32'h0000_1002;
  localparam int unsigned DRAM_FIELD_LSB = 8;
  localparam int unsigned DRAM_MIN_LOG2  = 27;
  localparam int unsigned DRAM_MAX_LOG2  = 31;

  typedef enum logic [1:0] {POL_RW, POL_RO, POL_W1C, POL_W1S} policy_e;
  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DWORD} size_e;

  // strobes from control to datapath; only legal accesses raise rd/wr
  typedef struct packed {
    logic                 rd;
    logic                 wr;
    logic                 dbl;
    logic [REG_IDX_W-1:0] idx;
  } strobe_t;

  function automatic policy_e regPolicy(int unsigned idx);
    case (idx)
      IDX_DEVID, IDX_STRAP, IDX_IRQSTAT: return POL_RO;
      IDX_RSTCAUSE, IDX_BOOTSTAT:        return POL_W1C;
      IDX_LOCK, IDX_MODDIS:              return POL_W1S;
      default:                           return POL_RW;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 64,
  parameter int unsigned WIDE_BASE = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqIn,
  input  logic        wrIn,
  input  logic [11:0] addrIn,
  input  logic [1:0]  sizeIn,
  output strobe_t     strbOut,
  output logic        ackOut,
  output logic        errOut
);

  localparam int unsigned WIDE_LAST = NUM_REGS - 2;

  logic [REG_IDX_W-1:0] wordIdx;
  logic  aligned, inRange, wideOk, sizeOk, legal;
  size_e sizeE;
  logic  ackQ, errQ;

  assign wordIdx = addrIn[11:2];
  assign sizeE   = size_e'(sizeIn);
  assign aligned = (addrIn[1:0] == 2'b00);
  assign inRange = (32'(wordIdx) < NUM_REGS);
  assign wideOk  = !wordIdx[0] && (32'(wordIdx) >= WIDE_BASE) &&
                   (32'(wordIdx) <= WIDE_LAST);

  always_comb begin
    case (sizeE)
      SZ_WORD:  sizeOk = 1'b1;
      SZ_DWORD: sizeOk = wideOk;
      default:  sizeOk = 1'b0;
    endcase
  end

  assign legal = aligned && inRange && sizeOk;

  always_comb begin
    strbOut.rd  = reqIn && !wrIn && legal;
    strbOut.wr  = reqIn &&  wrIn && legal;
    strbOut.dbl = (sizeE == SZ_DWORD);
    strbOut.idx = wordIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      ackQ <= reqIn;
      errQ <= reqIn && !legal;
    end
  end

  assign ackOut = ackQ;
  assign errOut = errQ;

  // R12
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqIn |=> ackOut);
  // R12
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqIn |=> !ackOut);
  // R12
  err_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> ackOut);

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 64,
  parameter int unsigned SEM_BASE  = 56,
  parameter int unsigned DRAM_LOG2 = 29,
  parameter logic [31:0] DEV_ID    = 32'h5C0F_1A02
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] strapIn,
  input  logic [31:0] modDisIn,
  input  strobe_t     strbIn,
  input  logic [63:0] wdataIn,
  output logic [63:0] rdataOut
);

  localparam int unsigned IDX_USE = $clog2(NUM_REGS);

  logic [31:0] regW [NUM_REGS];
  logic [63:0] rdataQ;
  logic [IDX_USE-1:0] idxLo, idxHi;

  function automatic logic [31:0] coldValue(int unsigned i);
    case (i)
      IDX_DEVID:    return DEV_ID;
      IDX_CTRLA:    return CTRLA_COLD;
      IDX_MEMCFG:   return MEMCFG_COLD;
      IDX_RSTCAUSE: return RSTCAUSE_COLD;
      IDX_BOOTSTAT: return BOOTSTAT_COLD;
      IDX_DRAMCTL:  return DRAMCTL_BASE |
                      (32'(DRAM_LOG2 - DRAM_MIN_LOG2) << DRAM_FIELD_LSB);
      IDX_DRAMSIZE: return 32'h1 << DRAM_LOG2;
      default:      return (i >= SEM_BASE) ? 32'h1 : 32'h0;
    endcase
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : gWord
    localparam policy_e POL = regPolicy(i);
    localparam logic [REG_IDX_W-1:0] MY = REG_IDX_W'(i);
    localparam logic [31:0] COLD = coldValue(i);

    logic [31:0] q, rstVal, nextLo;
    logic hitLo, hitHi;

    assign hitLo = strbIn.wr && (strbIn.idx == MY);

    if (i > 0) begin : gHi
      localparam logic [REG_IDX_W-1:0] PREV = REG_IDX_W'(i - 1);
      assign hitHi = strbIn.wr && strbIn.dbl && (strbIn.idx == PREV);
    end else begin : gNoHi
      assign hitHi = 1'b0;
    end

    if (i == IDX_STRAP) begin : gRstStrap
      assign rstVal = strapIn;
    end else if (i == IDX_MODDIS) begin : gRstModDis
      assign rstVal = modDisIn;
    end else begin : gRstConst
      assign rstVal = COLD;
    end

    if (POL == POL_RO) begin : gRo
      assign nextLo = q;
    end else if (POL == POL_W1C) begin : gW1c
      assign nextLo = q & ~wdataIn[31:0];
    end else if (POL == POL_W1S) begin : gW1s
      assign nextLo = q | wdataIn[31:0];
    end else begin : gRw
      assign nextLo = wdataIn[31:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)      q <= rstVal;
      else if (hitHi) q <= wdataIn[63:32];
      else if (hitLo) q <= nextLo;
    end

    assign regW[i] = q;
  end

  assign idxLo = strbIn.idx[IDX_USE-1:0];
  assign idxHi = idxLo + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)          rdataQ <= '0;
    else if (strbIn.rd) rdataQ <= {strbIn.dbl ? regW[idxHi] : 32'h0, regW[idxLo]};
    else                rdataQ <= '0;
  end

  assign rdataOut = rdataQ;

  // R5
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(regW[IDX_DEVID]) && $stable(regW[IDX_STRAP]) &&
                     $stable(regW[IDX_IRQSTAT])));
  // R6
  w1c_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (((regW[IDX_RSTCAUSE] & ~$past(regW[IDX_RSTCAUSE])) == 32'h0) &&
                     ((regW[IDX_BOOTSTAT] & ~$past(regW[IDX_BOOTSTAT])) == 32'h0)));
  // R7
  w1s_no_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (((~regW[IDX_LOCK] & $past(regW[IDX_LOCK])) == 32'h0) &&
                     ((~regW[IDX_MODDIS] & $past(regW[IDX_MODDIS])) == 32'h0)));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 64,
  parameter int unsigned WIDE_BASE = 32,
  parameter int unsigned SEM_BASE  = 56,
  parameter int unsigned DRAM_LOG2 = 29,
  parameter logic [31:0] DEV_ID    = 32'h5C0F_1A02
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] strapIn,
  input  logic [31:0] modDisIn,
  input  logic        reqIn,
  input  logic        wrIn,
  input  logic [11:0] addrIn,
  input  logic [1:0]  sizeIn,
  input  logic [63:0] wdataIn,
  output logic        ackOut,
  output logic        errOut,
  output logic [63:0] rdataOut
);

  localparam int unsigned MAX_REGS = WIN_BYTES / WORD_BYTES;

  if (DRAM_LOG2 < DRAM_MIN_LOG2 || DRAM_LOG2 > DRAM_MAX_LOG2) begin : gBadDram
    $error("DRAM_LOG2 must lie between 27 and 31");
  end
  if (NUM_REGS > MAX_REGS || NUM_REGS <= NUM_FIXED) begin : gBadCount
    $error("NUM_REGS must exceed the fixed words and fit the window");
  end
  if (WIDE_BASE[0] || WIDE_BASE < NUM_FIXED || SEM_BASE > NUM_REGS) begin : gBadWin
    $error("scratch window bounds are inconsistent");
  end

  strobe_t strb;

  sysctl_ctrl #(
    .NUM_REGS (NUM_REGS),
    .WIDE_BASE(WIDE_BASE)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .wrIn   (wrIn),
    .addrIn (addrIn),
    .sizeIn (sizeIn),
    .strbOut(strb),
    .ackOut (ackOut),
    .errOut (errOut)
  );

  sysctl_regs #(
    .NUM_REGS (NUM_REGS),
    .SEM_BASE (SEM_BASE),
    .DRAM_LOG2(DRAM_LOG2),
    .DEV_ID   (DEV_ID)
  ) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .strapIn (strapIn),
    .modDisIn(modDisIn),
    .strbIn  (strb),
    .wdataIn (wdataIn),
    .rdataOut(rdataOut)
  );

  // R9 R10 R11
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (rdataOut == 64'h0));

endmodule

// File: tb/sim_sysctl_regfile.sv
module sim_sysctl_regfile;

  localparam int NREG = 64;
  localparam int WBASE = 32;
  localparam int SBASE = 56;
  localparam logic [31:0] DEVID = 32'h5C0F_1A02;
  localparam logic [31:0] STRAP = 32'hA5A5_0F0F;
  localparam logic [31:0] MODDIS = 32'h0000_0030;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] strapIn = STRAP;
  logic [31:0] modDisIn = MODDIS;
  logic reqIn = 1'b0, wrIn = 1'b0;
  logic [11:0] addrIn = '0;
  logic [1:0] sizeIn = 2'd2;
  logic [63:0] wdataIn = '0;
  logic ackOut, errOut;
  logic [63:0] rdataOut;

  int checks = 0, errors = 0;
  bit done = 0, modelLive = 0;
  string curTag = "R12";

  always #10 clk = ~clk;

  sysctl_regfile #(.NUM_REGS(NREG), .WIDE_BASE(WBASE), .SEM_BASE(SBASE),
                   .DRAM_LOG2(29), .DEV_ID(DEVID)) u0 (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .modDisIn(modDisIn),
    .reqIn(reqIn), .wrIn(wrIn), .addrIn(addrIn), .sizeIn(sizeIn),
    .wdataIn(wdataIn), .ackOut(ackOut), .errOut(errOut), .rdataOut(rdataOut));

  // behavioural reference model
  bit [31:0] mem [NREG];
  bit eAck, eErr;
  bit [63:0] eData;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NREG; k++) mem[k] = (k >= SBASE) ? 32'h1 : 32'h0;
      mem[0] = DEVID; mem[1] = strapIn; mem[3] = 32'h35E; mem[4] = 32'h80000;
      mem[5] = 32'h80000000; mem[6] = 32'hC0; mem[8] = modDisIn;
      mem[9] = 32'h1202; mem[10] = 32'h20000000;
      eAck = 0; eErr = 0; eData = 0;
    end else begin
      int idx;
      bit ok;
      idx = int'(addrIn) / 4;
      eAck = reqIn; eErr = 0; eData = 0;
      if (reqIn) begin
        ok = (addrIn % 4 == 0) && idx < NREG &&
             (sizeIn == 2 || (sizeIn == 3 && idx % 2 == 0 && idx >= WBASE && idx <= NREG - 2));
        if (!ok) eErr = 1;
        else if (wrIn) begin
          if (sizeIn == 3) begin
            mem[idx] = wdataIn[31:0]; mem[idx+1] = wdataIn[63:32];
          end else if (idx == 5 || idx == 6) mem[idx] = mem[idx] & ~wdataIn[31:0];
          else if (idx == 7 || idx == 8) mem[idx] = mem[idx] | wdataIn[31:0];
          else if (idx > 2) mem[idx] = wdataIn[31:0];
        end else begin
          eData[31:0] = mem[idx];
          if (sizeIn == 3) eData[63:32] = mem[idx+1];
        end
      end
    end
    modelLive = 1;
  end

  always @(negedge clk) begin
    if (modelLive && !done) begin
      checks++;
      if (ackOut !== eAck || errOut !== eErr || rdataOut !== eData) begin
        errors++;
        $display("FAIL %s model: ack/err/data %b/%b/%h expected %b/%b/%h",
                 curTag, ackOut, errOut, rdataOut, eAck, eErr, eData);
      end
    end
  end

  task automatic acc(input bit w, input logic [11:0] a, input logic [1:0] s,
                     input logic [63:0] d, input logic [63:0] expD,
                     input bit expE, input string tag);
    curTag = tag;
    @(negedge clk);
    reqIn = 1; wrIn = w; addrIn = a; sizeIn = s; wdataIn = d;
    @(negedge clk);
    reqIn = 0; wrIn = 0;
    checks++;
    if (ackOut !== 1'b1 || errOut !== expE || rdataOut !== expD) begin
      errors++;
      $display("FAIL %s @%h: ack/err/data %b/%b/%h expected 1/%b/%h",
               tag, a, ackOut, errOut, rdataOut, expE, expD);
    end
    @(negedge clk);
    checks++;
    if (ackOut !== 1'b0 || errOut !== 1'b0) begin
      errors++;
      $display("FAIL R12 idle: ack/err %b/%b expected 0/0", ackOut, errOut);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    strapIn = 32'h0; modDisIn = 32'h0;
    // R1 cold constants
    acc(0, 12'h000, 2, 0, {32'h0, DEVID}, 0, "R1");
    acc(0, 12'h00C, 2, 0, 64'h35E, 0, "R1");
    acc(0, 12'h010, 2, 0, 64'h80000, 0, "R1");
    acc(0, 12'h014, 2, 0, 64'h80000000, 0, "R1");
    acc(0, 12'h018, 2, 0, 64'hC0, 0, "R1");
    acc(0, 12'h0E0, 2, 0, 64'h1, 0, "R1");
    acc(0, 12'h0FC, 2, 0, 64'h1, 0, "R1");
    // R2 strap and module-disable captured in reset
    acc(0, 12'h004, 2, 0, {32'h0, STRAP}, 0, "R2");
    acc(0, 12'h020, 2, 0, {32'h0, MODDIS}, 0, "R2");
    // R3 DRAM-derived words for 512 MiB
    acc(0, 12'h024, 2, 0, 64'h1202, 0, "R3");
    acc(0, 12'h028, 2, 0, 64'h20000000, 0, "R3");
    // R4 plain words
    acc(1, 12'h050, 2, 64'hFFFF_FFFF_DEAD_BEEF, 0, 0, "R4");
    acc(0, 12'h050, 2, 0, 64'hDEADBEEF, 0, "R4");
    acc(1, 12'h00C, 2, 64'h1234, 0, 0, "R4");
    acc(0, 12'h00C, 2, 0, 64'h1234, 0, "R4");
    // R5 read-only words ignore writes
    acc(1, 12'h000, 2, 64'hFFFFFFFF, 0, 0, "R5");
    acc(1, 12'h004, 2, 64'h0, 0, 0, "R5");
    acc(1, 12'h008, 2, 64'hFFFFFFFF, 0, 0, "R5");
    acc(0, 12'h000, 2, 0, {32'h0, DEVID}, 0, "R5");
    acc(0, 12'h004, 2, 0, {32'h0, STRAP}, 0, "R5");
    acc(0, 12'h008, 2, 0, 64'h0, 0, "R5");
    // R6 write-1-to-clear
    acc(1, 12'h014, 2, 64'h80000000, 0, 0, "R6");
    acc(0, 12'h014, 2, 0, 64'h0, 0, "R6");
    acc(1, 12'h018, 2, 64'h40, 0, 0, "R6");
    acc(0, 12'h018, 2, 0, 64'h80, 0, "R6");
    // R7 write-1-to-set
    acc(1, 12'h01C, 2, 64'h5, 0, 0, "R7");
    acc(1, 12'h01C, 2, 64'h2, 0, 0, "R7");
    acc(0, 12'h01C, 2, 0, 64'h7, 0, "R7");
    acc(1, 12'h020, 2, 64'h1, 0, 0, "R7");
    acc(0, 12'h020, 2, 0, 64'h31, 0, "R7");
    // R8 paired access inside the window
    acc(1, 12'h080, 3, 64'h1122_3344_5566_7788, 0, 0, "R8");
    acc(0, 12'h080, 2, 0, 64'h55667788, 0, "R8");
    acc(0, 12'h084, 2, 0, 64'h11223344, 0, "R8");
    acc(0, 12'h080, 3, 0, 64'h1122_3344_5566_7788, 0, "R8");
    acc(0, 12'h0F8, 3, 0, 64'h0000_0001_0000_0001, 0, "R8");
    // R9 paired access rejected outside the window or at odd index
    acc(0, 12'h050, 3, 0, 64'h0, 1, "R9");
    acc(1, 12'h078, 3, 64'hAAAA_AAAA_AAAA_AAAA, 0, 1, "R9");
    acc(1, 12'h084, 3, 64'hBBBB_BBBB_BBBB_BBBB, 0, 1, "R9");
    acc(0, 12'h084, 2, 0, 64'h11223344, 0, "R9");
    acc(0, 12'h088, 2, 0, 64'h0, 0, "R9");
    acc(0, 12'h078, 2, 0, 64'h0, 0, "R9");
    // R10 bad size or misaligned
    acc(0, 12'h00C, 0, 0, 64'h0, 1, "R10");
    acc(1, 12'h050, 1, 64'h0, 0, 1, "R10");
    acc(1, 12'h051, 2, 64'h0, 0, 1, "R10");
    acc(0, 12'h050, 2, 0, 64'hDEADBEEF, 0, "R10");
    // R11 beyond the last word
    acc(0, 12'h100, 2, 0, 64'h0, 1, "R11");
    acc(1, 12'hFFC, 2, 64'h1, 0, 1, "R11");
    acc(1, 12'h100, 2, 64'h1, 0, 1, "R11");
    acc(0, 12'h100, 2, 0, 64'h0, 1, "R11");
    // R12 back-to-back requests
    curTag = "R12";
    @(negedge clk);
    reqIn = 1; wrIn = 0; addrIn = 12'h00C; sizeIn = 2;
    @(negedge clk);
    addrIn = 12'h101;
    @(negedge clk);
    reqIn = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R12 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule